// File: doc/BRIEF.md
# Power-On Reset Supervisor with Qualification and Deglitch Timers

This block turns a set of digital supply and channel status flags into one active-high reset-release output for a multi-rail power subsystem. Its inputs come from three supply-level comparators (above lockout, above monitor level, below overvoltage), a thermal-shutdown flag, and a per-channel enable and power-good pair for each regulator channel. All threshold comparison happens elsewhere. This block only qualifies and times the flags it receives.

The output goes high only after every condition has held without a break for a long qualification window. The default window is 5700 ticks of 1 µs, i.e. 5.7 ms. Once high, the output drops only after some condition has failed without a break for a short deglitch window (default 10 ticks, i.e. 10 µs). A tick is one period of a prescaler that divides the system clock. Both windows restart from zero whenever their condition is broken for a single cycle. The power-good of a channel counts only while that channel is enabled. With every channel disabled, the block treats the state as a fault.

Top module: `por_sup`

## Requirements
- R1: `resetRelease` is 0 while `rstN` is low and right after it. Qualification counting begins only with the first clock edge after `rstN` is deasserted, even when all conditions already held during reset.
- R2: From the low state, `resetRelease` rises at the clock edge that completes RELEASE_TICKS*TICK_DIV consecutive cycles of "all conditions good", and not one cycle earlier.
- R3: From the high state, `resetRelease` falls at the clock edge that completes ASSERT_TICKS*TICK_DIV consecutive fault cycles. A shorter fault leaves it high.
- R4: Each of the following alone is a fault: `supplyAboveLockout`=0, `supplyAboveMonitor`=0, `supplyBelowOver`=0, `thermalTrip`=1.
- R5: Bit c of `chanGood` is a fault only while bit c of `chanEnable` is 1. A low power-good on a disabled channel has no effect on `resetRelease`.
- R6: When `chanEnable` is all zeros, the state counts as a fault. A high output falls after the deglitch window, and a low output stays low.
- R7: A single fault cycle during qualification restarts the qualification count from zero.
- R8: A single all-good cycle during the deglitch window restarts the deglitch count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyAboveLockout | input | 1 | 1 when the input supply is above the lockout level |
| supplyAboveMonitor | input | 1 | 1 when the input supply is above the monitor level |
| supplyBelowOver | input | 1 | 1 when the input supply is below the overvoltage level |
| thermalTrip | input | 1 | 1 during thermal shutdown |
| chanEnable | input | NUM_CHAN | Per-channel enable; bit c selects channel c for monitoring |
| chanGood | input | NUM_CHAN | Per-channel power-good flag |
| resetRelease | output | 1 | Active-high reset release |

## Verification
The embedded assertions check the following on every cycle:
- the output rises only after a cycle in which all conditions held;
- the output falls only after a cycle with a fault;
- a low output never leaves the low state while all channels are disabled;
- the shared timer is cleared one edge after any restart strobe and never passes its largest limit.

The exact window lengths, the restart of each window after a one-cycle interruption, the masking of disabled channels' power-good, and the effect of each individual supply and thermal flag are shown only by the bench's timed scenarios. These scenarios sample one cycle before and at the expected edge.

// File: rtl/por_sup_pkg.sv
package por_sup_pkg;
  // Strobes from control to the shared timer in the datapath
  typedef struct packed {
    logic run;       // advance prescaler / tick count
    logic clr;       // restart the window from zero
    logic useAstLim; // compare against the deglitch limit instead of release limit
  } tmrCtl_t;

  typedef enum logic {
    ST_LOW  = 1'b0,
    ST_HIGH = 1'b1
  } supState_t;
endpackage

// File: rtl/por_sup_dp.sv
module por_sup_dp
  import por_sup_pkg::*;
#(
  parameter int NUM_CHAN      = 5,
  parameter int TICK_DIV      = 100,
  parameter int RELEASE_TICKS = 5700,
  parameter int ASSERT_TICKS  = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  tmrCtl_t             ctl,
  input  logic                supplyAboveLockout,
  input  logic                supplyAboveMonitor,
  input  logic                supplyBelowOver,
  input  logic                thermalTrip,
  input  logic [NUM_CHAN-1:0] chanEnable,
  input  logic [NUM_CHAN-1:0] chanGood,
  output logic                allOk,
  output logic                anyEnabled,
  output logic                atLimit
);
  localparam int LIM_MAX = (RELEASE_TICKS > ASSERT_TICKS) ? RELEASE_TICKS : ASSERT_TICKS;
  localparam int PRE_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int TCK_W   = (LIM_MAX > 1) ? $clog2(LIM_MAX) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [TCK_W-1:0] REL_LAST = TCK_W'(RELEASE_TICKS - 1);
  localparam logic [TCK_W-1:0] AST_LAST = TCK_W'(ASSERT_TICKS - 1);
  localparam logic [TCK_W-1:0] TCK_TOP  = TCK_W'(LIM_MAX - 1);

  logic [NUM_CHAN-1:0] chanOk;
  logic [PRE_W-1:0]    preCnt;
  logic [TCK_W-1:0]    tickCnt;
  logic                supplyOk;
  logic                preWrap;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_mask
    assign chanOk[c] = !chanEnable[c] || chanGood[c];
  end

  assign supplyOk   = supplyAboveLockout && supplyAboveMonitor && supplyBelowOver && !thermalTrip;
  assign anyEnabled = |chanEnable;
  assign allOk      = supplyOk && anyEnabled && (&chanOk);

  assign preWrap = (preCnt == PRE_LAST);
  assign atLimit = preWrap && (tickCnt == (ctl.useAstLim ? AST_LAST : REL_LAST));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (ctl.clr) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (ctl.run) begin
      if (preWrap) begin
        preCnt  <= '0;
        tickCnt <= tickCnt + TCK_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  // R7
  tmr_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clr |=> (preCnt == '0 && tickCnt == '0));

  // R2
  tmr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= TCK_TOP);
endmodule

// File: rtl/por_sup_ctrl.sv
module por_sup_ctrl
  import por_sup_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    allOk,
  input  logic    anyEnabled,
  input  logic    atLimit,
  output tmrCtl_t ctl,
  output logic    relOut
);
  supState_t state, stateNext;
  logic      watchCond;
  logic      fire;

  // In the low state the window qualifies good cycles; in the high state it counts faults
  assign watchCond = (state == ST_LOW) ? allOk : !allOk;
  assign fire      = watchCond && atLimit;

  always_comb begin
    ctl.run       = watchCond && !fire;
    ctl.clr       = !watchCond || fire;
    ctl.useAstLim = (state == ST_HIGH);
    stateNext     = state;
    if (fire) stateNext = (state == ST_LOW) ? ST_HIGH : ST_LOW;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_LOW;
    else       state <= stateNext;
  end

  assign relOut = (state == ST_HIGH);

  // R2
  rise_qualified_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(relOut) |-> $past(allOk));

  // R3
  fall_on_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(relOut) |-> !$past(allOk));

  // R6
  none_enabled_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!anyEnabled && !relOut) |=> !relOut);
endmodule

// File: rtl/por_sup.sv
module por_sup
  import por_sup_pkg::*;
#(
  parameter int NUM_CHAN      = 5,
  parameter int TICK_DIV      = 100,
  parameter int RELEASE_TICKS = 5700,
  parameter int ASSERT_TICKS  = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                supplyAboveLockout,
  input  logic                supplyAboveMonitor,
  input  logic                supplyBelowOver,
  input  logic                thermalTrip,
  input  logic [NUM_CHAN-1:0] chanEnable,
  input  logic [NUM_CHAN-1:0] chanGood,
  output logic                resetRelease
);
  tmrCtl_t tmrCtl;
  logic    allOk;
  logic    anyEnabled;
  logic    atLimit;

  por_sup_dp #(
    .NUM_CHAN(NUM_CHAN), .TICK_DIV(TICK_DIV),
    .RELEASE_TICKS(RELEASE_TICKS), .ASSERT_TICKS(ASSERT_TICKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(tmrCtl),
    .supplyAboveLockout(supplyAboveLockout), .supplyAboveMonitor(supplyAboveMonitor),
    .supplyBelowOver(supplyBelowOver), .thermalTrip(thermalTrip),
    .chanEnable(chanEnable), .chanGood(chanGood),
    .allOk(allOk), .anyEnabled(anyEnabled), .atLimit(atLimit)
  );

  por_sup_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .allOk(allOk), .anyEnabled(anyEnabled),
    .atLimit(atLimit), .ctl(tmrCtl), .relOut(resetRelease)
  );
endmodule

// File: tb/por_sup_bench.sv
module por_sup_bench;
  localparam int NCH = 5;
  localparam int DIV = 4;
  localparam int REL = 5;   // release window = 20 cycles
  localparam int AST = 3;   // deglitch window = 12 cycles
  localparam int NVEC = 22;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lockOk = 1'b1, monOk = 1'b1, overOk = 1'b1, therm = 1'b0;
  logic [NCH-1:0] en = '1, good = '1;
  logic relOut;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  por_sup #(.NUM_CHAN(NCH), .TICK_DIV(DIV), .RELEASE_TICKS(REL), .ASSERT_TICKS(AST)) u_por_sup (
    .clk(clk), .rstN(rstN), .supplyAboveLockout(lockOk), .supplyAboveMonitor(monOk),
    .supplyBelowOver(overOk), .thermalTrip(therm), .chanEnable(en), .chanGood(good),
    .resetRelease(relOut)
  );

  // flags: {lock, mon, over, thermal}; all good = 4'b1110
  function automatic logic [31:0] mk(input logic [3:0] fl, input logic [4:0] e, input logic [4:0] g,
                                     input int w, input logic x, input int r);
    return {fl, e, g, 10'(w), 4'(r), 3'b000, x};
  endfunction

  localparam logic [31:0] VEC [NVEC] = '{
    mk(4'b1110, 5'h1f, 5'h1f, 19, 1'b0, 2),  // R2 one cycle short
    mk(4'b1110, 5'h1f, 5'h1f,  1, 1'b1, 2),  // R2 exact edge
    mk(4'b1010, 5'h1f, 5'h1f, 11, 1'b1, 3),  // R3 short fault holds
    mk(4'b1010, 5'h1f, 5'h1f,  1, 1'b0, 4),  // R4 monitor flag
    mk(4'b1110, 5'h04, 5'h04, 20, 1'b1, 5),  // R5 disabled bad goods ignored
    mk(4'b1110, 5'h04, 5'h1b, 12, 1'b0, 5),  // R5 enabled bad good
    mk(4'b1110, 5'h1f, 5'h1f, 20, 1'b1, 2),
    mk(4'b1100, 5'h1f, 5'h1f, 11, 1'b1, 3),  // R3
    mk(4'b1110, 5'h1f, 5'h1f,  1, 1'b1, 8),  // R8 one good cycle
    mk(4'b1100, 5'h1f, 5'h1f, 11, 1'b1, 8),  // R8 window restarted
    mk(4'b1100, 5'h1f, 5'h1f,  1, 1'b0, 4),  // R4 overvoltage flag
    mk(4'b1110, 5'h1f, 5'h1f, 15, 1'b0, 7),  // R7
    mk(4'b1111, 5'h1f, 5'h1f,  1, 1'b0, 7),  // R7 one fault cycle
    mk(4'b1110, 5'h1f, 5'h1f, 19, 1'b0, 7),  // R7 count restarted
    mk(4'b1110, 5'h1f, 5'h1f,  1, 1'b1, 7),
    mk(4'b0110, 5'h1f, 5'h1f, 12, 1'b0, 4),  // R4 lockout flag
    mk(4'b1110, 5'h00, 5'h1f, 40, 1'b0, 6),  // R6 none enabled stays low
    mk(4'b1110, 5'h1f, 5'h1f, 20, 1'b1, 2),
    mk(4'b1111, 5'h1f, 5'h1f, 12, 1'b0, 4),  // R4 thermal flag
    mk(4'b1110, 5'h1f, 5'h1f, 20, 1'b1, 2),
    mk(4'b1110, 5'h00, 5'h1f, 12, 1'b0, 6),  // R6 disabling all drops output
    mk(4'b1110, 5'h00, 5'h00,  5, 1'b0, 6)   // R6
  };

  task automatic check(input logic exp, input string req);
    checks++;
    if (relOut !== exp) begin
      errors++;
      $display("FAIL %s resetRelease got %b expected %b at %0t", req, relOut, exp, $time);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    waitN(3);
    check(1'b0, "R1");                 // in reset
    rstN = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      {lockOk, monOk, overOk, therm} = VEC[v][31:28];
      en   = VEC[v][27:23];
      good = VEC[v][22:18];
      waitN(int'(VEC[v][17:8]));
      check(VEC[v][0], $sformatf("R%0d vec%0d", VEC[v][7:4], v));
    end
    // R1: async reset from high, counting only starts after release
    {lockOk, monOk, overOk, therm} = 4'b1110; en = '1; good = '1;
    waitN(20);
    check(1'b1, "R2");
    rstN = 1'b0;
    #1 check(1'b0, "R1");
    waitN(10);
    check(1'b0, "R1");
    rstN = 1'b1;
    waitN(19);
    check(1'b0, "R1");
    waitN(1);
    check(1'b1, "R1");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end
endmodule